// File: doc/BRIEF.md
# Counting Semaphore Cell

A single synchronisation cell that lets hardware threads coordinate through a 16-bit counting semaphore. It has two request ports that act in the same cycle: a read port that carries a view code and a requester ID, and a write port that carries a view code and a data word. A read through one of the two count views is an acquire: it returns the count as it stood before the operation and decrements the count when the count is above zero. A write through either count view is a release: it increments the count, which saturates at 0xFFFF, and the write data plays no part.

An acquire through the waiting view that finds the count at zero raises a stall flag with its response, leaves the count unchanged and records the requester in a bitmap of waiting threads. The next release sends a one-cycle wake pulse to every recorded requester and empties the bitmap. The thread scheduler outside the cell decides when a stalled requester retries. The cell also has a raw view, a tag view and two queue-style views. The tag view uses the same tag word layout as a queue cell, with the queue-mode bit always clear.

Top module: `sem_cell`

## Requirements
- R1: A read in view 4 (waiting acquire) or view 5 (try acquire) returns the count as it stands after any release in the same cycle and before its own decrement. It then decrements the count when that value is above zero.
- R2: A view-4 read that finds the count at zero returns 0 with `rsp_stall` high, leaves the count at zero and records `rd_id` in the waiting bitmap. A view-5 read at zero returns 0, does not stall and changes nothing.
- R3: A write in view 4 or view 5 adds one to the count unless the count is already 0xFFFF. The value of `wr_data` has no effect on the count.
- R4: A release in either view 4 or view 5 drives `wake` high for exactly one cycle on each bit that was set in the waiting bitmap, and it empties the bitmap.
- R5: A view-0 (raw) read returns the count as it was before any write in the same cycle. A view-0 write has no effect.
- R6: Reads in views 2 and 3 (queue views) and in views 6 to 15 return 0. Writes in those views have no effect.
- R7: A view-1 (tag) read returns a word with the turn bit at bit 16, the full flag at bit 1 and the empty flag at bit 0. Every other bit reads 0, including bit 17, which is the queue-mode bit. A view-1 write loads those three flags from the same bit positions.
- R8: After reset the count, the tag flags, the waiting bitmap, `wake`, `rsp_valid` and `rsp_stall` are all zero.
- R9: When a release and an acquire reach the cell in the same cycle, the release is applied first and the acquire is then evaluated against the updated count.
- R10: `rsp_valid` goes high in the cycle after each accepted read and at no other time. `rsp_stall` is high only together with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request present |
| rd_view | input | 4 | View code of the read |
| rd_id | input | $clog2(N_REQ) | Requester issuing the read |
| wr_valid | input | 1 | Write request present |
| wr_view | input | 4 | View code of the write |
| wr_data | input | DATA_W | Write data (only the tag view uses it) |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | DATA_W | Read response value |
| rsp_stall | output | 1 | Blocking acquire found the count at zero |
| wake | output | N_REQ | One-cycle wake pulse per requester |

## Verification
Every read response, stall flag and wake pulse appears one clock after the edge that captures its request. The count and the bitmap also change at that edge, so the next request already sees them. The driver applies one request pair per cycle just after a falling edge and queues the expected response from its own model of count, flags and bitmap. The monitor pops one entry a little after each rising edge and compares it, so every result is checked exactly one cycle after its stimulus. Internal state that a request could have disturbed is read back through the raw and tag views in the following cycle.

// File: rtl/semcell_pkg.sv
package semcell_pkg;

    typedef enum logic [3:0] {
        V_RAW     = 4'd0,
        V_TAG     = 4'd1,
        V_Q_WAIT  = 4'd2,
        V_Q_TRY   = 4'd3,
        V_CNT_WAIT = 4'd4,
        V_CNT_TRY = 4'd5
    } view_e;

    // Bit positions shared with the queue cell's tag word.
    localparam int TAG_TURN_BIT = 16;
    localparam int TAG_QMODE_BIT = 17;
    localparam int TAG_FULL_BIT = 1;
    localparam int TAG_EMPTY_BIT = 0;

    typedef struct packed {
        logic turn;
        logic full;
        logic empty;
    } tag_t;

endpackage

// File: rtl/sem_count_next.sv
module sem_count_next #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             rel,
    input  logic             acq,
    input  logic             acq_wait,
    output logic [CNT_W-1:0] cnt_d,
    output logic [CNT_W-1:0] pre_val,
    output logic             blocked
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] after_rel;

    always_comb begin
        // Release first, saturating at the top of the range.
        after_rel = cnt_q;
        if (rel && (cnt_q != CNT_MAX)) begin
            after_rel = cnt_q + 1'b1;
        end
        pre_val = after_rel;
        cnt_d   = after_rel;
        blocked = 1'b0;
        if (acq) begin
            if (after_rel != '0) begin
                cnt_d = after_rel - 1'b1;
            end else begin
                blocked = acq_wait;
            end
        end
    end
endmodule

// File: rtl/sem_wait_list.sv
module sem_wait_list #(
    parameter int N_REQ = 8
) (
    input  logic [N_REQ-1:0]         map_q,
    input  logic                     rel,
    input  logic                     blocked,
    input  logic [$clog2(N_REQ)-1:0] blk_id,
    output logic [N_REQ-1:0]         map_d,
    output logic [N_REQ-1:0]         wake_d
);
    for (genvar g = 0; g < N_REQ; g++) begin : g_req
        always_comb begin
            wake_d[g] = rel & map_q[g];
            map_d[g]  = (map_q[g] & ~rel) |
                        (blocked && (blk_id == ($clog2(N_REQ))'(g)));
        end
    end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import semcell_pkg::*;
#(
    parameter int N_REQ  = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_valid,
    input  logic [3:0]               rd_view,
    input  logic [$clog2(N_REQ)-1:0] rd_id,
    input  logic                     wr_valid,
    input  logic [3:0]               wr_view,
    input  logic [DATA_W-1:0]        wr_data,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_data,
    output logic                     rsp_stall,
    output logic [N_REQ-1:0]         wake
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        tag_t              tag;
        logic [N_REQ-1:0]  map;
        logic [N_REQ-1:0]  wake;
        logic              rsp_v;
        logic              rsp_stall;
        logic [DATA_W-1:0] rsp_data;
    } state_t;

    state_t st_d, st_q;

    logic             rel, acq, acq_wait, blocked;
    logic [CNT_W-1:0] cnt_next, pre_val;
    logic [N_REQ-1:0] map_next, wake_next;
    logic [DATA_W-1:0] tag_word;
    logic [CNT_W-1:0] cnt_q;
    logic             unused_wdata;

    assign rel      = wr_valid && (wr_view == V_CNT_WAIT || wr_view == V_CNT_TRY);
    assign acq      = rd_valid && (rd_view == V_CNT_WAIT || rd_view == V_CNT_TRY);
    assign acq_wait = (rd_view == V_CNT_WAIT);
    assign cnt_q    = st_q.cnt;
    assign unused_wdata = ^wr_data;

    sem_count_next #(.CNT_W(CNT_W)) u_count (
        .cnt_q   (st_q.cnt),
        .rel     (rel),
        .acq     (acq),
        .acq_wait(acq_wait),
        .cnt_d   (cnt_next),
        .pre_val (pre_val),
        .blocked (blocked)
    );

    sem_wait_list #(.N_REQ(N_REQ)) u_wait (
        .map_q  (st_q.map),
        .rel    (rel),
        .blocked(blocked),
        .blk_id (rd_id),
        .map_d  (map_next),
        .wake_d (wake_next)
    );

    always_comb begin
        tag_word                = '0;
        tag_word[TAG_TURN_BIT]  = st_q.tag.turn;
        tag_word[TAG_FULL_BIT]  = st_q.tag.full;
        tag_word[TAG_EMPTY_BIT] = st_q.tag.empty;
        tag_word[TAG_QMODE_BIT] = 1'b0;
    end

    always_comb begin
        st_d           = st_q;
        st_d.cnt       = cnt_next;
        st_d.map       = map_next;
        st_d.wake      = wake_next;
        st_d.rsp_v     = rd_valid;
        st_d.rsp_stall = blocked;
        st_d.rsp_data  = '0;
        if (rd_valid) begin
            case (rd_view)
                V_RAW:      st_d.rsp_data = DATA_W'(st_q.cnt);
                V_TAG:      st_d.rsp_data = tag_word;
                V_CNT_WAIT,
                V_CNT_TRY:  st_d.rsp_data = DATA_W'(pre_val);
                default:    st_d.rsp_data = '0;
            endcase
        end
        if (wr_valid && wr_view == V_TAG) begin
            st_d.tag.turn  = wr_data[TAG_TURN_BIT];
            st_d.tag.full  = wr_data[TAG_FULL_BIT];
            st_d.tag.empty = wr_data[TAG_EMPTY_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_v;
    assign rsp_data  = st_q.rsp_data;
    assign rsp_stall = st_q.rsp_stall;
    assign wake      = st_q.wake;
endmodule

// File: rtl/sem_cell_chk.sv
module sem_cell_chk #(
    parameter int N_REQ  = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic [3:0]        rd_view,
    input logic              wr_valid,
    input logic [3:0]        wr_view,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_stall,
    input logic [N_REQ-1:0]  wake,
    input logic [CNT_W-1:0]  cnt
);
    logic is_rel, is_acq, is_qread;
    assign is_rel   = wr_valid && (wr_view == 4'd4 || wr_view == 4'd5);
    assign is_acq   = rd_valid && (rd_view == 4'd4 || rd_view == 4'd5);
    assign is_qread = rd_valid && (rd_view == 4'd2 || rd_view == 4'd3);

    a_r10_stall_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stall |-> rsp_valid);

    a_r10_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rsp_valid);

    a_r2_stall_keeps_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stall |-> (cnt == '0));

    a_r4_wake_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
        (wake != '0) |-> $past(is_rel));

    a_r3_saturating_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rel && !is_acq && cnt != '1) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    a_r3_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rel && !is_acq && cnt == '1) |=> (cnt == '1));

    a_r6_queue_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        is_qread |=> (rsp_data == '0));
endmodule

bind sem_cell sem_cell_chk #(.N_REQ(N_REQ), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_valid (rd_valid),
    .rd_view  (rd_view),
    .wr_valid (wr_valid),
    .wr_view  (wr_view),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data),
    .rsp_stall(rsp_stall),
    .wake     (wake),
    .cnt      (cnt_q)
);

// File: tb/test_sem_cell.sv
`timescale 1ns/1ps
module test_sem_cell;
    localparam int N_REQ = 8;
    localparam int ID_W = $clog2(N_REQ);
    localparam int DATA_W = 32;
    localparam logic [3:0] VB = 4'd0, VC = 4'd1, VE = 4'd2, VET = 4'd3, VP = 4'd4, VPT = 4'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_valid = 1'b0;
    logic [3:0] rd_view = '0;
    logic [ID_W-1:0] rd_id = '0;
    logic wr_valid = 1'b0;
    logic [3:0] wr_view = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic rsp_stall;
    logic [N_REQ-1:0] wake;

    always #5 clk = ~clk;

    sem_cell #(.N_REQ(N_REQ), .DATA_W(DATA_W), .CNT_W(16)) i_sem_cell (
        .clk(clk), .rst_n(rst_n),
        .rd_valid(rd_valid), .rd_view(rd_view), .rd_id(rd_id),
        .wr_valid(wr_valid), .wr_view(wr_view), .wr_data(wr_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_stall(rsp_stall),
        .wake(wake)
    );

    typedef struct {
        logic              v;
        logic              stall;
        logic [DATA_W-1:0] data;
        logic [N_REQ-1:0]  wk;
        string             req;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Bench model of the cell.
    int unsigned m_cnt = 0;
    bit m_turn = 0, m_full = 0, m_empty = 0;
    logic [N_REQ-1:0] m_map = '0;

    task automatic chk(input string req, input string what, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic step(input bit rv, input logic [3:0] rvw, input int rid,
                        input bit wv, input logic [3:0] wvw, input logic [DATA_W-1:0] wd,
                        input string req);
        exp_t e;
        bit rel, acq;
        int unsigned after;
        rel = wv && (wvw == VP || wvw == VPT);
        acq = rv && (rvw == VP || rvw == VPT);
        after = (rel && m_cnt < 32'hFFFF) ? m_cnt + 1 : m_cnt;
        e.v = rv; e.stall = 1'b0; e.data = '0; e.req = req;
        e.wk = rel ? m_map : '0;
        if (rv) begin
            case (rvw)
                VB: e.data = DATA_W'(m_cnt);
                VC: e.data = (DATA_W'(m_turn) << 16) | (DATA_W'(m_full) << 1) | DATA_W'(m_empty);
                VP, VPT: begin
                    e.data = DATA_W'(after);
                    e.stall = (after == 0) && (rvw == VP);
                end
                default: e.data = '0;
            endcase
        end
        @(negedge clk);
        rd_valid = rv; rd_view = rvw; rd_id = ID_W'(rid);
        wr_valid = wv; wr_view = wvw; wr_data = wd;
        sb.push_back(e);
        // model update
        if (acq && after > 0) after = after - 1;
        m_cnt = after;
        if (rel) m_map = '0;
        if (e.stall) m_map[rid] = 1'b1;
        if (wv && wvw == VC) begin
            m_turn = wd[16]; m_full = wd[1]; m_empty = wd[0];
        end
    endtask

    task automatic rd(input logic [3:0] vw, input int id, input string req);
        step(1, vw, id, 0, 4'd0, '0, req);
    endtask

    task automatic wr(input logic [3:0] vw, input logic [DATA_W-1:0] d, input string req);
        step(0, 4'd0, 0, 1, vw, d, req);
    endtask

    // Monitor: results are due one clock after the capturing edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(e.req, "rsp_valid", DATA_W'(rsp_valid), DATA_W'(e.v));
                chk(e.req, "rsp_stall", DATA_W'(rsp_stall), DATA_W'(e.stall));
                chk(e.req, "wake", DATA_W'(wake), DATA_W'(e.wk));
                if (e.v) chk(e.req, "rsp_data", rsp_data, e.data);
            end
        end
    end

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state at the ports
        chk("R8", "rsp_valid", DATA_W'(rsp_valid), '0);
        chk("R8", "wake", DATA_W'(wake), '0);
        chk("R8", "rsp_stall", DATA_W'(rsp_stall), '0);
        rd(VB, 0, "R8");
        rd(VC, 0, "R8");
        // R2: try and waiting acquire at zero
        rd(VPT, 1, "R2");
        rd(VB, 0, "R2");
        rd(VP, 3, "R2");
        rd(VP, 5, "R2");
        rd(VB, 0, "R2");
        // R6: queue and unused views
        wr(VE, 32'h1234, "R6");
        wr(VET, 32'h99, "R6");
        wr(4'd11, 32'h7, "R6");
        rd(VE, 0, "R6");
        rd(VET, 0, "R6");
        rd(4'd9, 0, "R6");
        rd(VB, 0, "R6");
        rd(VC, 0, "R6");
        // R5: raw write ignored
        wr(VB, 32'd55, "R5");
        rd(VB, 0, "R5");
        // R4: release wakes requesters 3 and 5; R3: data ignored
        wr(VP, 32'hABCD, "R4");
        wr(VPT, 32'h0, "R3");
        rd(VB, 0, "R3");
        // R1: acquires return pre-decrement value
        rd(VP, 0, "R1");
        rd(VPT, 0, "R1");
        rd(VB, 0, "R1");
        // R4: waiter 6, then try-view release wakes it once
        rd(VP, 6, "R4");
        wr(VPT, 32'h0, "R4");
        wr(VP, 32'h0, "R4");
        rd(VPT, 0, "R4");
        rd(VPT, 0, "R4");
        // R9: release and waiting acquire in one cycle at zero
        step(1, VP, 2, 1, VP, '0, "R9");
        rd(VB, 0, "R9");
        // R5: raw read sees count before same-cycle release
        step(1, VB, 0, 1, VP, '0, "R5");
        rd(VPT, 0, "R5");
        // R3: saturation
        for (int i = 0; i < 65535; i++) wr(VPT, 32'(i), "R3");
        rd(VB, 0, "R3");
        wr(VP, 32'h0, "R3");
        rd(VB, 0, "R3");
        // R9: at the top, release saturates then acquire decrements
        step(1, VPT, 0, 1, VP, '0, "R9");
        rd(VB, 0, "R9");
        // R7: tag view
        wr(VC, 32'h0001_0003, "R7");
        rd(VC, 0, "R7");
        wr(VC, 32'hFFFE_FFFC, "R7");
        rd(VC, 0, "R7");
        wr(VC, 32'h0000_0002, "R7");
        rd(VC, 0, "R7");
        rd(VB, 0, "R7");
        // R10: idle cycles give no response
        step(0, 4'd0, 0, 0, 4'd0, '0, "R10");
        step(0, 4'd0, 0, 0, 4'd0, '0, "R10");
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule